// File: doc/BRIEF.md
# Trap Entry and Return CSR Unit

This block holds the privilege mode and the trap-handling control and status registers of a processor core with machine (M), supervisor (S) and user (U) modes. When the core takes a trap, the block is given the event code, an interrupt flag, the PC of the interrupted or faulting instruction, a trap value and the mode the trap is routed to. It pushes the two-level enable and privilege stack, records the trap in that mode's epc, cause and tval registers, and returns the handler address one cycle later. On an MRET or SRET it pops the stack, restores the privilege mode and returns the saved epc as the next PC.

A shared status register carries the enable, previous-enable, previous-privilege and memory-privilege fields. The supervisor status address shows only the supervisor fields of that same register. Each of M and S has its own tvec, epc, cause, tval and scratch register. Software reads and writes them through a small indexed CSR port. Deciding which interrupt to take, instruction decode and legality checks are left to the surrounding core.

Top module: `trap_csr_unit`

## Requirements
- R1: On a trap from mode y into mode x, the block sets xPIE to the old xIE, clears xIE, sets xPP to y (SPP is 1 when y is S, else 0) and sets the privilege mode to x.
- R2: On a trap into mode x, x's epc takes the trap PC and x's tval takes the trap value. x's cause takes the event code in its low bits with the interrupt flag in bit XLEN-1 (1 = interrupt, 0 = exception). The other mode's registers keep their values.
- R3: The tvec MODE field is bits [1:0]; bit 1 always reads 0, and bit 0 is 1 for vectored and 0 for direct. The next PC for a trap is the tvec base (tvec with bits [1:0] cleared). In vectored mode an interrupt instead goes to base + 4 × code.
- R4: A trap routed to S while the current mode is M is taken into M: M's status fields and registers are updated and S's registers keep their values.
- R5: On MRET or SRET from mode x, the block sets xIE to xPIE, sets the privilege mode to xPP, sets xPIE to 1 and sets xPP to U. The next PC is x's epc.
- R6: On an xRET whose popped mode is not M, MPRV is cleared. On an MRET that pops M, MPRV keeps its value.
- R7: The supervisor status view reads only SIE (bit 0), SPIE (bit 2) and SPP (bit 4), with all other bits reading 0. A write through the view changes only those three fields.
- R8: The machine status layout is SIE bit 0, MIE bit 1, SPIE bit 2, MPIE bit 3, SPP bit 4, MPP bits [6:5] and MPRV bit 7, with all higher bits reading 0. Privilege encodings are U=0, S=1 and M=3. A write of 2 to MPP stores 0.
- R9: The scratch registers change only through software writes, never on trap entry or return.
- R10: A trap takes precedence over an xRET in the same cycle, and the xRET is then dropped. A software CSR write in a cycle with a trap or an xRET is dropped.
- R11: After reset the mode is M, the status register reads 0, every bank register reads 0 and redirect_valid is 0. redirect_valid is 1 exactly in the cycle after a trap or xRET input.
- R12: CSR address bit 3 selects the bank (0 = M, 1 = S). The low three bits select the register: 0 status, 1 tvec, 2 epc, 3 cause, 4 tval, 5 scratch. Indices 6 and 7 read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| trap_valid | input | 1 | A trap is taken this cycle |
| trap_code | input | CAUSE_W | Event code of the trap |
| trap_is_irq | input | 1 | 1 when the trap is an interrupt |
| trap_pc | input | XLEN | PC of the interrupted or faulting instruction |
| trap_tval | input | XLEN | Trap value to record |
| trap_to_s | input | 1 | Route the trap to S (otherwise to M) |
| xret_valid | input | 1 | An xRET executes this cycle |
| xret_s | input | 1 | 1 for SRET, 0 for MRET |
| csr_we | input | 1 | Software CSR write strobe |
| csr_addr | input | 4 | CSR index (bank in bit 3, register in bits 2:0) |
| csr_wdata | input | XLEN | Software write data |
| csr_rdata | output | XLEN | Combinational read data at csr_addr |
| priv_mode | output | 2 | Current privilege mode |
| redirect_valid | output | 1 | The next PC is valid this cycle |
| redirect_pc | output | XLEN | Handler address or return address |

## Verification
The assertions assume that MPP never holds the reserved value 2 and that reset is held across at least one clock edge. They also assume that no xRET arrives from a mode below the one it returns from. The bench therefore issues SRET only from S or M and MRET only from M. The reserved MPP value is driven only through a software write, which the block legalises. Simultaneous trap, xRET and software-write inputs appear only in the cases that exercise the precedence rule.

// File: rtl/trap_csr_pkg.sv
package trap_csr_pkg;

    localparam logic [1:0] PRIV_U = 2'd0;
    localparam logic [1:0] PRIV_S = 2'd1;
    localparam logic [1:0] PRIV_M = 2'd3;

    localparam logic [2:0] IDX_STAT    = 3'd0;
    localparam logic [2:0] IDX_TVEC    = 3'd1;
    localparam logic [2:0] IDX_EPC     = 3'd2;
    localparam logic [2:0] IDX_CAUSE   = 3'd3;
    localparam logic [2:0] IDX_TVAL    = 3'd4;
    localparam logic [2:0] IDX_SCRATCH = 3'd5;

    localparam int STAT_W = 8;

    // packed order equals the register image, bit 7 down to bit 0
    typedef struct packed {
        logic       mprv;
        logic [1:0] mpp;
        logic       spp;
        logic       mpie;
        logic       spie;
        logic       mie;
        logic       sie;
    } stat_t;

    localparam logic [STAT_W-1:0] SVIEW_MASK = 8'h15;

endpackage

// File: rtl/trap_csr_status.sv
module trap_csr_status
    import trap_csr_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              trap_take,
    input  logic              trap_into_s,
    input  logic              xret_take,
    input  logic              xret_s,
    input  logic              sw_we_m,
    input  logic              sw_we_s,
    input  logic [STAT_W-1:0] sw_wdata,
    output stat_t             stat_q,
    output logic [1:0]        priv_q
);

    typedef struct packed {
        stat_t      st;
        logic [1:0] priv;
    } st_state_t;

    st_state_t cur_q, nxt_d;

    always_comb begin
        nxt_d = cur_q;
        if (trap_take) begin
            if (trap_into_s) begin
                nxt_d.st.spie = cur_q.st.sie;
                nxt_d.st.sie  = 1'b0;
                nxt_d.st.spp  = (cur_q.priv == PRIV_S);
                nxt_d.priv    = PRIV_S;
            end else begin
                nxt_d.st.mpie = cur_q.st.mie;
                nxt_d.st.mie  = 1'b0;
                nxt_d.st.mpp  = cur_q.priv;
                nxt_d.priv    = PRIV_M;
            end
        end else if (xret_take) begin
            if (xret_s) begin
                nxt_d.priv    = cur_q.st.spp ? PRIV_S : PRIV_U;
                nxt_d.st.sie  = cur_q.st.spie;
                nxt_d.st.spie = 1'b1;
                nxt_d.st.spp  = 1'b0;
                nxt_d.st.mprv = 1'b0;
            end else begin
                nxt_d.priv    = cur_q.st.mpp;
                nxt_d.st.mie  = cur_q.st.mpie;
                nxt_d.st.mpie = 1'b1;
                nxt_d.st.mpp  = PRIV_U;
                if (cur_q.st.mpp != PRIV_M) begin
                    nxt_d.st.mprv = 1'b0;
                end
            end
        end else if (sw_we_m) begin
            nxt_d.st = stat_t'(sw_wdata);
            if (nxt_d.st.mpp == 2'd2) begin
                nxt_d.st.mpp = PRIV_U;
            end
        end else if (sw_we_s) begin
            nxt_d.st.sie  = sw_wdata[0];
            nxt_d.st.spie = sw_wdata[2];
            nxt_d.st.spp  = sw_wdata[4];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cur_q.st   <= '0;
            cur_q.priv <= PRIV_M;
        end else begin
            cur_q <= nxt_d;
        end
    end

    assign stat_q = cur_q.st;
    assign priv_q = cur_q.priv;

endmodule

// File: rtl/trap_csr_bank.sv
module trap_csr_bank
    import trap_csr_pkg::*;
#(
    parameter int XLEN = 32
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            hw_trap,
    input  logic [XLEN-1:0] hw_epc,
    input  logic [XLEN-1:0] hw_cause,
    input  logic [XLEN-1:0] hw_tval,
    input  logic            sw_we,
    input  logic [2:0]      sw_idx,
    input  logic [XLEN-1:0] sw_wdata,
    output logic [XLEN-1:0] tvec_q,
    output logic [XLEN-1:0] epc_q,
    output logic [XLEN-1:0] scratch_q,
    output logic [XLEN-1:0] rd_data
);

    typedef struct packed {
        logic [XLEN-1:0] tvec;
        logic [XLEN-1:0] epc;
        logic [XLEN-1:0] cause;
        logic [XLEN-1:0] tval;
        logic [XLEN-1:0] scratch;
    } bank_t;

    bank_t cur_q, nxt_d;

    always_comb begin
        nxt_d = cur_q;
        if (hw_trap) begin
            nxt_d.epc   = hw_epc;
            nxt_d.cause = hw_cause;
            nxt_d.tval  = hw_tval;
        end else if (sw_we) begin
            unique case (sw_idx)
                IDX_TVEC:    nxt_d.tvec    = {sw_wdata[XLEN-1:2], 1'b0, sw_wdata[0]};
                IDX_EPC:     nxt_d.epc     = sw_wdata;
                IDX_CAUSE:   nxt_d.cause   = sw_wdata;
                IDX_TVAL:    nxt_d.tval    = sw_wdata;
                IDX_SCRATCH: nxt_d.scratch = sw_wdata;
                default:     ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cur_q <= '0;
        end else begin
            cur_q <= nxt_d;
        end
    end

    always_comb begin
        unique case (sw_idx)
            IDX_TVEC:    rd_data = cur_q.tvec;
            IDX_EPC:     rd_data = cur_q.epc;
            IDX_CAUSE:   rd_data = cur_q.cause;
            IDX_TVAL:    rd_data = cur_q.tval;
            IDX_SCRATCH: rd_data = cur_q.scratch;
            default:     rd_data = '0;
        endcase
    end

    assign tvec_q    = cur_q.tvec;
    assign epc_q     = cur_q.epc;
    assign scratch_q = cur_q.scratch;

endmodule

// File: rtl/trap_csr_vector.sv
module trap_csr_vector #(
    parameter int XLEN    = 32,
    parameter int CAUSE_W = 5
) (
    input  logic [XLEN-1:0]    tvec,
    input  logic               is_irq,
    input  logic [CAUSE_W-1:0] code,
    output logic [XLEN-1:0]    target
);

    logic [XLEN-1:0] base;
    logic [XLEN-1:0] offset;

    always_comb begin
        base   = {tvec[XLEN-1:2], 2'b00};
        offset = XLEN'(code) << 2;
        if (tvec[0] && is_irq) begin
            target = base + offset;
        end else begin
            target = base;
        end
    end

endmodule

// File: rtl/trap_csr_unit.sv
module trap_csr_unit
    import trap_csr_pkg::*;
#(
    parameter int XLEN    = 32,
    parameter int CAUSE_W = 5
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               trap_valid,
    input  logic [CAUSE_W-1:0] trap_code,
    input  logic               trap_is_irq,
    input  logic [XLEN-1:0]    trap_pc,
    input  logic [XLEN-1:0]    trap_tval,
    input  logic               trap_to_s,
    input  logic               xret_valid,
    input  logic               xret_s,
    input  logic               csr_we,
    input  logic [3:0]         csr_addr,
    input  logic [XLEN-1:0]    csr_wdata,
    output logic [XLEN-1:0]    csr_rdata,
    output logic [1:0]         priv_mode,
    output logic               redirect_valid,
    output logic [XLEN-1:0]    redirect_pc
);

    localparam int NBANK = 2;

    typedef struct packed {
        logic            valid;
        logic [XLEN-1:0] pc;
    } redir_t;

    stat_t           stat;
    logic [1:0]      priv_q;
    logic            into_s;
    logic            xret_take;
    logic            sw_ok;
    logic [2:0]      idx;
    logic            bank_sel;
    logic [XLEN-1:0] hw_cause;
    logic [XLEN-1:0] tvec_w    [NBANK];
    logic [XLEN-1:0] epc_w     [NBANK];
    logic [XLEN-1:0] scratch_w [NBANK];
    logic [XLEN-1:0] rd_w      [NBANK];
    logic [XLEN-1:0] trap_target;
    redir_t          redir_q, redir_d;

    assign into_s    = trap_to_s && (priv_q != PRIV_M);
    assign xret_take = xret_valid && !trap_valid;
    assign sw_ok     = csr_we && !trap_valid && !xret_valid;
    assign idx       = csr_addr[2:0];
    assign bank_sel  = csr_addr[3];
    assign hw_cause  = {trap_is_irq, (XLEN-1)'(trap_code)};

    trap_csr_status u_status (
        .clk        (clk),
        .rst_n      (rst_n),
        .trap_take  (trap_valid),
        .trap_into_s(into_s),
        .xret_take  (xret_take),
        .xret_s     (xret_s),
        .sw_we_m    (sw_ok && !bank_sel && idx == IDX_STAT),
        .sw_we_s    (sw_ok &&  bank_sel && idx == IDX_STAT),
        .sw_wdata   (csr_wdata[STAT_W-1:0]),
        .stat_q     (stat),
        .priv_q     (priv_q)
    );

    for (genvar g = 0; g < NBANK; g++) begin : g_bank
        logic hit_trap;
        assign hit_trap = trap_valid && ((g == 1) ? into_s : !into_s);

        trap_csr_bank #(.XLEN(XLEN)) u_bank (
            .clk      (clk),
            .rst_n    (rst_n),
            .hw_trap  (hit_trap),
            .hw_epc   (trap_pc),
            .hw_cause (hw_cause),
            .hw_tval  (trap_tval),
            .sw_we    (sw_ok && (bank_sel == (g == 1)) && idx != IDX_STAT),
            .sw_idx   (idx),
            .sw_wdata (csr_wdata),
            .tvec_q   (tvec_w[g]),
            .epc_q    (epc_w[g]),
            .scratch_q(scratch_w[g]),
            .rd_data  (rd_w[g])
        );
    end

    trap_csr_vector #(.XLEN(XLEN), .CAUSE_W(CAUSE_W)) u_vector (
        .tvec  (into_s ? tvec_w[1] : tvec_w[0]),
        .is_irq(trap_is_irq),
        .code  (trap_code),
        .target(trap_target)
    );

    always_comb begin
        redir_d       = redir_q;
        redir_d.valid = trap_valid || xret_valid;
        if (trap_valid) begin
            redir_d.pc = trap_target;
        end else if (xret_valid) begin
            redir_d.pc = xret_s ? epc_w[1] : epc_w[0];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            redir_q <= '0;
        end else begin
            redir_q <= redir_d;
        end
    end

    always_comb begin
        if (idx == IDX_STAT) begin
            if (bank_sel) begin
                csr_rdata = XLEN'(stat & SVIEW_MASK);
            end else begin
                csr_rdata = XLEN'(stat);
            end
        end else begin
            csr_rdata = bank_sel ? rd_w[1] : rd_w[0];
        end
    end

    assign priv_mode      = priv_q;
    assign redirect_valid = redir_q.valid;
    assign redirect_pc    = redir_q.pc;

endmodule

// File: rtl/trap_csr_unit_chk.sv
module trap_csr_unit_chk
    import trap_csr_pkg::*;
#(
    parameter int XLEN = 32
) (
    input logic            clk,
    input logic            rst_n,
    input logic            trap_valid,
    input logic            trap_to_s,
    input logic            xret_valid,
    input logic            xret_s,
    input logic            csr_we,
    input logic [3:0]      csr_addr,
    input logic [1:0]      priv_mode,
    input logic            redirect_valid,
    input stat_t           stat,
    input logic [XLEN-1:0] m_scr,
    input logic [XLEN-1:0] s_scr
);

    AST_M_TRAP_PUSH: assert property (@(posedge clk) disable iff (!rst_n)
        trap_valid && (!trap_to_s || priv_mode == PRIV_M) |=>
        !stat.mie && stat.mpie == $past(stat.mie) && stat.mpp == $past(priv_mode) && priv_mode == PRIV_M); // R1

    AST_S_TRAP_PUSH: assert property (@(posedge clk) disable iff (!rst_n)
        trap_valid && trap_to_s && priv_mode != PRIV_M |=>
        !stat.sie && stat.spie == $past(stat.sie) && priv_mode == PRIV_S); // R1

    AST_NO_DOWNWARD: assert property (@(posedge clk) disable iff (!rst_n)
        trap_valid && priv_mode == PRIV_M |=> priv_mode == PRIV_M); // R4

    AST_MRET_POP: assert property (@(posedge clk) disable iff (!rst_n)
        !trap_valid && xret_valid && !xret_s |=>
        stat.mpie && stat.mpp == PRIV_U && priv_mode == $past(stat.mpp)); // R5

    AST_SRET_POP: assert property (@(posedge clk) disable iff (!rst_n)
        !trap_valid && xret_valid && xret_s |=> stat.spie && !stat.spp && !stat.mprv); // R6

    AST_MPRV_DROP: assert property (@(posedge clk) disable iff (!rst_n)
        !trap_valid && xret_valid && !xret_s && stat.mpp != PRIV_M |=> !stat.mprv); // R6

    AST_SCRATCH_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !(csr_we && csr_addr[2:0] == IDX_SCRATCH) |=> $stable(m_scr) && $stable(s_scr)); // R9

    AST_TRAP_OVER_XRET: assert property (@(posedge clk) disable iff (!rst_n)
        trap_valid && xret_valid && !trap_to_s |=> !stat.mie && priv_mode == PRIV_M); // R10

    AST_REDIRECT_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        (trap_valid || xret_valid) |=> redirect_valid); // R11

    AST_REDIRECT_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !(trap_valid || xret_valid) |=> !redirect_valid); // R11

    AST_MPP_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
        stat.mpp != 2'd2); // R8

endmodule

bind trap_csr_unit trap_csr_unit_chk #(.XLEN(XLEN)) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .trap_valid    (trap_valid),
    .trap_to_s     (trap_to_s),
    .xret_valid    (xret_valid),
    .xret_s        (xret_s),
    .csr_we        (csr_we),
    .csr_addr      (csr_addr),
    .priv_mode     (priv_mode),
    .redirect_valid(redirect_valid),
    .stat          (stat),
    .m_scr         (scratch_w[0]),
    .s_scr         (scratch_w[1])
);

// File: tb/trap_csr_unit_bench.sv
module trap_csr_unit_bench;

    localparam int XLEN    = 32;
    localparam int CAUSE_W = 5;

    localparam logic [3:0] A_MST = 4'h0, A_MTV = 4'h1, A_MEP = 4'h2, A_MCA = 4'h3,
                           A_MTL = 4'h4, A_MSC = 4'h5, A_M6  = 4'h6;
    localparam logic [3:0] A_SST = 4'h8, A_STV = 4'h9, A_SEP = 4'hA, A_SCA = 4'hB,
                           A_STL = 4'hC, A_SSC = 4'hD;

    logic               clk = 1'b0;
    logic               rst_n = 1'b0;
    logic               trap_valid = 1'b0;
    logic [CAUSE_W-1:0] trap_code = '0;
    logic               trap_is_irq = 1'b0;
    logic [XLEN-1:0]    trap_pc = '0;
    logic [XLEN-1:0]    trap_tval = '0;
    logic               trap_to_s = 1'b0;
    logic               xret_valid = 1'b0;
    logic               xret_s = 1'b0;
    logic               csr_we = 1'b0;
    logic [3:0]         csr_addr = '0;
    logic [XLEN-1:0]    csr_wdata = '0;
    logic [XLEN-1:0]    csr_rdata;
    logic [1:0]         priv_mode;
    logic               redirect_valid;
    logic [XLEN-1:0]    redirect_pc;

    int total = 0;
    int bad = 0;
    logic [XLEN-1:0] exp_q[$];

    always #10 clk = ~clk;

    trap_csr_unit #(.XLEN(XLEN), .CAUSE_W(CAUSE_W)) u_trap_csr_unit (.*);

    task automatic check(input string tag, input logic [XLEN-1:0] act, input logic [XLEN-1:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // monitor: pops the scoreboard whenever a redirect appears
    always @(negedge clk) begin
        if (rst_n && redirect_valid) begin
            if (exp_q.size() == 0) begin
                check("R11 unexpected redirect", redirect_pc, '1);
            end else begin
                check("R3/R5 redirect pc", redirect_pc, exp_q.pop_front());
            end
        end
    end

    task automatic drive(input logic tv, input logic [CAUSE_W-1:0] code, input logic irq,
                         input logic [XLEN-1:0] pc, input logic [XLEN-1:0] tval, input logic tos,
                         input logic xv, input logic xs,
                         input logic we, input logic [3:0] addr, input logic [XLEN-1:0] wd,
                         input logic [XLEN-1:0] exp_pc);
        @(negedge clk);
        trap_valid = tv; trap_code = code; trap_is_irq = irq; trap_pc = pc;
        trap_tval = tval; trap_to_s = tos; xret_valid = xv; xret_s = xs;
        csr_we = we; csr_addr = addr; csr_wdata = wd;
        if (tv || xv) exp_q.push_back(exp_pc);
        @(negedge clk);
        trap_valid = 1'b0; xret_valid = 1'b0; csr_we = 1'b0;
    endtask

    task automatic wr(input logic [3:0] a, input logic [XLEN-1:0] d);
        drive(0, '0, 0, '0, '0, 0, 0, 0, 1, a, d, '0);
    endtask

    task automatic trap(input logic [CAUSE_W-1:0] code, input logic irq, input logic [XLEN-1:0] pc,
                        input logic [XLEN-1:0] tval, input logic tos, input logic [XLEN-1:0] exp_pc);
        drive(1, code, irq, pc, tval, tos, 0, 0, 0, '0, '0, exp_pc);
    endtask

    task automatic xret(input logic s, input logic [XLEN-1:0] exp_pc);
        drive(0, '0, 0, '0, '0, 0, 1, s, 0, '0, '0, exp_pc);
    endtask

    task automatic rd(input string tag, input logic [3:0] a, input logic [XLEN-1:0] exp);
        @(negedge clk);
        csr_addr = a;
        #1;
        check(tag, csr_rdata, exp);
    endtask

    task automatic chk_priv(input string tag, input logic [1:0] exp);
        @(negedge clk);
        check(tag, XLEN'(priv_mode), XLEN'(exp));
    endtask

    initial begin
        #4000000;
        total++; bad++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // reset state, R11
        chk_priv("R11 reset priv", 2'd3);
        check("R11 reset redirect_valid", XLEN'(redirect_valid), 0);
        rd("R11 reset mstatus", A_MST, 0);
        rd("R11 reset mepc", A_MEP, 0);
        rd("R12 unused index", A_M6, 0);

        wr(A_MSC, 32'hDEAD);
        wr(A_SSC, 32'hBEEF);
        wr(A_MTV, 32'h1003);
        rd("R3 tvec mode bit1 reads 0", A_MTV, 32'h1001);
        wr(A_MTV, 32'h1000);
        wr(A_MST, 32'h2);
        rd("R8 MIE bit1", A_MST, 32'h2);

        // direct exception into M, R1 R2 R3
        trap(5'd2, 0, 32'h400, 32'h55, 0, 32'h1000);
        rd("R1 mstatus after trap", A_MST, 32'h68);
        rd("R2 mepc", A_MEP, 32'h400);
        rd("R2 mcause", A_MCA, 32'h2);
        rd("R2 mtval", A_MTL, 32'h55);
        rd("R2 sepc untouched", A_SEP, 0);

        xret(0, 32'h400);
        rd("R5 mstatus after mret", A_MST, 32'h0A);
        chk_priv("R5 priv after mret", 2'd3);

        // vectored, R3
        wr(A_MTV, 32'h2001);
        trap(5'd7, 1, 32'h404, 0, 0, 32'h201C);
        rd("R2 mcause interrupt", A_MCA, 32'h80000007);
        trap(5'd3, 0, 32'h408, 0, 0, 32'h2000);
        rd("R1 mstatus second trap", A_MST, 32'h60);

        // MRET to S with MPRV set, R5 R6
        wr(A_MEP, 32'h3000);
        wr(A_MST, 32'hA0);
        rd("R8 mstatus write", A_MST, 32'hA0);
        xret(0, 32'h3000);
        chk_priv("R5 mret to S", 2'd1);
        rd("R6 mprv cleared", A_MST, 32'h08);

        // supervisor traps, R1 R2 R7
        wr(A_STV, 32'h5000);
        wr(A_SST, 32'h1);
        rd("R7 sstatus view", A_SST, 32'h1);
        rd("R7 mstatus shares sie", A_MST, 32'h09);
        trap(5'd8, 0, 32'h3004, 32'h77, 1, 32'h5000);
        chk_priv("R1 priv S after trap", 2'd1);
        rd("R1 sstatus after trap", A_SST, 32'h14);
        rd("R2 sepc", A_SEP, 32'h3004);
        rd("R2 scause", A_SCA, 32'h8);
        rd("R2 stval", A_STL, 32'h77);
        rd("R2 mepc untouched", A_MEP, 32'h3000);

        xret(1, 32'h3004);
        chk_priv("R5 sret to S", 2'd1);
        rd("R5 sstatus after sret", A_SST, 32'h05);
        xret(1, 32'h3004);
        chk_priv("R5 sret to U", 2'd0);

        // from U into M, vectored interrupt
        trap(5'd3, 1, 32'h600, 0, 0, 32'h200C);
        chk_priv("R1 priv M from U", 2'd3);
        rd("R1 mpp holds U", A_MST, 32'h05);

        // routed to S while in M, R4
        trap(5'd5, 0, 32'h700, 0, 1, 32'h2000);
        chk_priv("R4 stays M", 2'd3);
        rd("R4 mepc written", A_MEP, 32'h700);
        rd("R4 sepc kept", A_SEP, 32'h3004);

        // MRET popping M keeps MPRV, R6
        wr(A_MST, 32'hE0);
        xret(0, 32'h700);
        rd("R6 mprv kept", A_MST, 32'h88);

        // supervisor view write, R7
        wr(A_SST, 32'hFFFFFFFF);
        rd("R7 mstatus after view write", A_MST, 32'h9D);
        rd("R7 sstatus masked", A_SST, 32'h15);

        // reserved MPP, R8
        wr(A_MST, 32'h40);
        rd("R8 mpp legalised", A_MST, 32'h0);

        // precedence, R10
        drive(1, 5'd1, 0, 32'h800, 0, 0, 0, 0, 1, A_MEP, 32'h1234, 32'h2000);
        rd("R10 sw write dropped", A_MEP, 32'h800);
        drive(1, 5'd4, 0, 32'h900, 0, 0, 1, 0, 0, A_MST, 0, 32'h2000);
        rd("R10 trap over mret mepc", A_MEP, 32'h900);
        rd("R10 trap over mret mstatus", A_MST, 32'h60);

        // scratch, R9
        rd("R9 mscratch kept", A_MSC, 32'hDEAD);
        rd("R9 sscratch kept", A_SSC, 32'hBEEF);

        repeat (2) @(negedge clk);
        check("R11 scoreboard drained", XLEN'(exp_q.size()), 0);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule